// File: doc/BRIEF.md
# Time-over-Threshold Pulse Width Digitiser

This block measures how long a discriminated detector pulse stays high. The width of that pulse is a measure of the deposited particle energy. The block combines a coarse count of whole clock cycles with a fine interpolation inside each cycle. The fine part comes from a tapped delay line that sits outside the block. On every clock edge the block receives one registered snapshot of all the delay-line taps. A pulse edge that travels into the line leaves a thermometer pattern in the snapshot. The number of taps the edge has passed shows how long ago, in fine bins, the edge arrived before the sampling edge.

The block recognises the snapshot that first shows the rising edge and the snapshot that first shows the falling edge. It turns each of these snapshots into a fine code by counting taps rather than by searching for a transition, so an isolated bubble does not shift the code. It then forms one width value in fine-bin units and presents it for a single cycle with a valid strobe. A pulse that lasts longer than a configurable number of coarse cycles is discarded and flagged instead.

The controller is a five-state machine:
- ARMING waits for an all-zero snapshot and moves to WATCH.
- WATCH moves to INPULSE on any nonzero snapshot.
- INPULSE moves to REPORT when a falling edge shows in the low taps. It moves to OVERRUN when the cycle limit is reached first.
- REPORT moves to WATCH if its snapshot is all zero and to ARMING otherwise.
- OVERRUN always moves to ARMING.

Reset enters ARMING.

Top module: `tdc_pulse_width`

## Requirements
- R1: While reset is held, and after reset until an all-zero snapshot has been seen, `width_vld_o` and `ovf_o` stay low, even if the snapshots show a pulse ending.
- R2: The start of a pulse is the first nonzero snapshot that follows an all-zero snapshot. Bit 0 of `tap_snap` is the tap nearest the line input. The start fine code is the number of ones in the whole snapshot.
- R3: After a start, the end of the pulse is the first snapshot with at least one zero among taps 0 to PERIOD_TAPS-1. The stop fine code is the number of zeros in the whole snapshot. Zeros in higher taps alone do not end the pulse.
- R4: The width is D×PERIOD_TAPS + start code − stop code. D is the number of clock edges from the start snapshot to the stop snapshot. The width is on `width_o` with `width_vld_o` high for exactly the one cycle that follows the edge that takes in the stop snapshot. Otherwise `width_o` is zero.
- R5: A pulse with D = MAX_COARSE is reported normally. If the snapshot taken MAX_COARSE edges after the start still has no zero in the low taps, `ovf_o` is high for one cycle and no width is reported for that pulse. The block then re-arms only after an all-zero snapshot.
- R6: A rising edge whose first nonzero snapshot arrives in the cycle in which `width_vld_o` is high is ignored. The block then waits for an all-zero snapshot, so that pulse yields neither a width nor an overflow.
- R7: Swapping the two adjacent tap bits at the single transition of a start or stop snapshot (a bubble) leaves the reported width unchanged.
- R8: `width_vld_o` and `ovf_o` are never high together, and each stays high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; one period is one coarse step |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_snap | input | NTAPS (36) | Registered delay-line tap snapshot, bit 0 nearest the line input |
| width_o | output | WW (12) | Measured width in fine bins, zero when not valid |
| width_vld_o | output | 1 | One-cycle strobe marking a valid width |
| ovf_o | output | 1 | One-cycle strobe marking a discarded over-long pulse |

## Verification
The assertions rely on physically consistent snapshots. Every pulse is at least 35 fine bins long. The line is quiet for long enough before each rising edge that the snapshot before it is all zero. A bubble is only an adjacent swap at the single transition. Under these conditions the stop snapshot always has a zero in the low window, the width is never zero, and an overrun follows a saturated low window. The bench builds every snapshot from an ideal model of the line: each tap holds the pulse level one bin further in the past. It draws random pulse starts and widths from a fixed seed with gaps of at least three periods. Directed cases fill in the overflow boundary, the ignored edge and the bubble phase.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    typedef enum logic [2:0] {
        ST_ARMING  = 3'd0,
        ST_WATCH   = 3'd1,
        ST_INPULSE = 3'd2,
        ST_REPORT  = 3'd3,
        ST_OVERRUN = 3'd4
    } tdc_state_e;

endpackage

// File: rtl/tdc_ones_count.sv
// Counts the set bits of a tap snapshot with a ripple of partial sums.
module tdc_ones_count #(
    parameter int N  = 36,
    parameter int OW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec_i,
    output logic [OW-1:0] ones_o
);

    logic [OW-1:0] part [N+1];

    assign part[0] = '0;

    for (genvar gi = 0; gi < N; gi++) begin : g_sum
        assign part[gi+1] = part[gi] + OW'(vec_i[gi]);
    end

    assign ones_o = part[N];

endmodule

// File: rtl/tdc_edge_sense.sv
// Derives the two edge conditions the controller needs from a snapshot.
module tdc_edge_sense #(
    parameter int NTAPS       = 36,
    parameter int PERIOD_TAPS = 33
) (
    input  logic [NTAPS-1:0] snap_i,
    output logic             any_high_o,
    output logic             low_gap_o
);

    assign any_high_o = |snap_i;

    // The falling edge is looked for only in the taps that span one period;
    // taps beyond it may still carry the rising edge one cycle later.
    if (PERIOD_TAPS >= NTAPS) begin : g_full_win
        assign low_gap_o = ~(&snap_i);
    end else begin : g_part_win
        assign low_gap_o = ~(&snap_i[PERIOD_TAPS-1:0]);
    end

endmodule

// File: rtl/tdc_width_calc.sv
// Combines the coarse distance and the two fine codes into a width.
module tdc_width_calc #(
    parameter int PERIOD_TAPS = 33,
    parameter int CW          = 7,
    parameter int FW          = 6,
    parameter int WW          = 12
) (
    input  logic [CW-1:0] coarse_i,
    input  logic [FW-1:0] start_fine_i,
    input  logic [FW-1:0] stop_fine_i,
    output logic [WW-1:0] width_o
);

    logic [WW-1:0] coarse_bins;

    assign coarse_bins = WW'(coarse_i) * WW'(PERIOD_TAPS);
    assign width_o     = coarse_bins + WW'(start_fine_i) - WW'(stop_fine_i);

endmodule

// File: rtl/tdc_pulse_width.sv
module tdc_pulse_width
    import tdc_pkg::*;
#(
    parameter int NTAPS       = 36,
    parameter int PERIOD_TAPS = 33,
    parameter int MAX_COARSE  = 64,
    localparam int CW = $clog2(MAX_COARSE + 1),
    localparam int FW = $clog2(NTAPS + 1),
    localparam int WW = $clog2((MAX_COARSE + 1) * PERIOD_TAPS + NTAPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTAPS-1:0] tap_snap,
    output logic [WW-1:0]    width_o,
    output logic             width_vld_o,
    output logic             ovf_o
);

    tdc_state_e    state_q, state_d;
    logic [CW-1:0] coarse_q;
    logic [FW-1:0] start_fine_q;
    logic [FW-1:0] stop_fine_q;
    logic [FW-1:0] ones_cnt;
    logic          any_high;
    logic          low_gap;
    logic [WW-1:0] width_calc;

    tdc_ones_count #(.N(NTAPS), .OW(FW)) u_ones (
        .vec_i  (tap_snap),
        .ones_o (ones_cnt)
    );

    tdc_edge_sense #(.NTAPS(NTAPS), .PERIOD_TAPS(PERIOD_TAPS)) u_sense (
        .snap_i     (tap_snap),
        .any_high_o (any_high),
        .low_gap_o  (low_gap)
    );

    tdc_width_calc #(
        .PERIOD_TAPS (PERIOD_TAPS),
        .CW          (CW),
        .FW          (FW),
        .WW          (WW)
    ) u_calc (
        .coarse_i     (coarse_q),
        .start_fine_i (start_fine_q),
        .stop_fine_i  (stop_fine_q),
        .width_o      (width_calc)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMING:  if (!any_high) state_d = ST_WATCH;
            ST_WATCH:   if (any_high)  state_d = ST_INPULSE;
            ST_INPULSE: begin
                if (low_gap)
                    state_d = ST_REPORT;
                else if (coarse_q == CW'(MAX_COARSE - 1))
                    state_d = ST_OVERRUN;
            end
            ST_REPORT:  state_d = any_high ? ST_ARMING : ST_WATCH;
            ST_OVERRUN: state_d = ST_ARMING;
            default:    state_d = ST_ARMING;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMING;
        else        state_q <= state_d;
    end

    // Coarse counter and fine-code capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coarse_q     <= '0;
            start_fine_q <= '0;
            stop_fine_q  <= '0;
        end else begin
            if (state_q == ST_WATCH && any_high) begin
                coarse_q     <= '0;
                start_fine_q <= ones_cnt;
            end
            if (state_q == ST_INPULSE) begin
                coarse_q <= coarse_q + 1'b1;
                if (low_gap)
                    stop_fine_q <= FW'(NTAPS) - ones_cnt;
            end
        end
    end

    // Outputs
    always_comb begin
        width_o     = '0;
        width_vld_o = 1'b0;
        ovf_o       = 1'b0;
        unique case (state_q)
            ST_REPORT: begin
                width_o     = width_calc;
                width_vld_o = 1'b1;
            end
            ST_OVERRUN: ovf_o = 1'b1;
            ST_ARMING, ST_WATCH, ST_INPULSE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/tdc_pulse_width_chk.sv
module tdc_pulse_width_chk #(
    parameter int NTAPS       = 36,
    parameter int PERIOD_TAPS = 33,
    parameter int MAX_COARSE  = 64,
    localparam int WW = $clog2((MAX_COARSE + 1) * PERIOD_TAPS + NTAPS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NTAPS-1:0] tap_snap,
    input logic [WW-1:0]    width_o,
    input logic             width_vld_o,
    input logic             ovf_o
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            quiet_in_reset_chk: assert (!width_vld_o && !ovf_o);
        end
    end

    // R8
    vld_ovf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(width_vld_o && ovf_o));

    // R8
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        width_vld_o |=> !width_vld_o);

    // R8
    ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> !ovf_o);

    // R3
    vld_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        width_vld_o |-> $past(~(&tap_snap[PERIOD_TAPS-1:0])));

    // R5
    ovf_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(&tap_snap[PERIOD_TAPS-1:0]));

    // R2
    ovf_line_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(tap_snap != '0));

    // R4
    width_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        width_vld_o |-> (width_o != '0));

    // R6
    no_ovf_after_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        width_vld_o |=> !ovf_o);

endmodule

bind tdc_pulse_width tdc_pulse_width_chk #(
    .NTAPS       (NTAPS),
    .PERIOD_TAPS (PERIOD_TAPS),
    .MAX_COARSE  (MAX_COARSE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tap_snap    (tap_snap),
    .width_o     (width_o),
    .width_vld_o (width_vld_o),
    .ovf_o       (ovf_o)
);

// File: tb/sim_tdc_pulse_width.sv
module sim_tdc_pulse_width;

    localparam int NT = 36;
    localparam int P  = 33;
    localparam int MX = 64;
    localparam int WW = $clog2((MX + 1) * P + NT + 1);
    localparam int NP = 120;
    localparam int K_ACC = 0;
    localparam int K_OVF = 1;
    localparam int K_IGN = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] tap_snap = '0;
    logic [WW-1:0] width_o;
    logic          width_vld_o;
    logic          ovf_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int ps [NP];
    int pe [NP];
    int kind [NP];
    int evc [NP];
    int ew [NP];
    int bub_t;
    int ign_lo, ign_hi;

    always #2 clk = ~clk;

    tdc_pulse_width #(.NTAPS(NT), .PERIOD_TAPS(P), .MAX_COARSE(MX)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tap_snap    (tap_snap),
        .width_o     (width_o),
        .width_vld_o (width_vld_o),
        .ovf_o       (ovf_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit lvl(input int t);
        for (int p = 0; p < NP; p++) begin
            if (ps[p] > t) return 1'b0;
            if (t < pe[p]) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Ideal line: tap j holds the level j+1 bins before the sampling edge.
    function automatic logic [NT-1:0] snap_at(input int c);
        logic [NT-1:0] v;
        logic tmp;
        int b;
        for (int j = 0; j < NT; j++) v[j] = lvl(c * P - 1 - j);
        if (c * P >= bub_t) begin
            b = -1;
            for (int j = 1; j < NT; j++) if (b < 0 && v[j] != v[0]) b = j;
            if (b > 0) begin
                tmp = v[b-1]; v[b-1] = v[b]; v[b] = tmp;
            end
        end
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R4 watchdog: actual %0d expected %0d", 200000, 0);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int t, w, k, kf, c_end, nx, cc;
        bit ev, eo;
        string tag;
        void'($urandom(32'd7351));

        // build the pulse train
        t = 20 * P;
        for (int i = 0; i < NP; i++) begin
            ps[i] = t;
            k = (t + P) / P;
            case (i)
                0: pe[i] = t + 35;                        // shortest pulse
                1: pe[i] = (k + MX) * P - 7;              // D = MAX_COARSE, kept
                2: pe[i] = (k + MX + 1) * P - 1;          // D = MAX_COARSE+1, overflow
                3: pe[i] = t + 100;
                4: begin                                  // rises in the report cycle
                    ps[i] = evc[3] * P + 5;
                    pe[i] = ps[i] + 80;
                end
                5: pe[i] = t + 2 * P;
                default: begin
                    w = 35 + int'($urandom % ((MX + 3) * P));
                    pe[i] = t + w;
                end
            endcase
            k  = (ps[i] + P) / P;
            kf = (pe[i] + P) / P;
            ew[i] = pe[i] - ps[i];
            if (i == 4) begin
                kind[i] = K_IGN;
                evc[i]  = kf;
                ign_lo  = k;
                ign_hi  = kf + 2;
            end else if (kf - k > MX) begin
                kind[i] = K_OVF;
                evc[i]  = k + MX;
            end else begin
                kind[i] = K_ACC;
                evc[i]  = kf;
            end
            t = pe[i] + 3 * P + 40 + int'($urandom % 150);
        end
        bub_t = ps[NP/2] - 2 * P;

        // R1: quiet in reset and until the line has been seen idle
        repeat (3) begin
            @(negedge clk);
            chk(!width_vld_o && !ovf_o, "R1", "outputs in reset", int'({width_vld_o, ovf_o}), 0);
        end
        rst_n = 1'b1;
        tap_snap = '1;
        repeat (4) begin
            @(negedge clk);
            chk(!width_vld_o && !ovf_o, "R1", "busy line after reset", int'({width_vld_o, ovf_o}), 0);
        end
        tap_snap = {{(NT-5){1'b1}}, 5'b0};
        @(negedge clk);
        chk(!width_vld_o && !ovf_o, "R1", "falling seen while arming", int'({width_vld_o, ovf_o}), 0);
        tap_snap = '0;
        repeat (3) begin
            @(negedge clk);
            chk(!width_vld_o && !ovf_o, "R1", "falling not reported", int'({width_vld_o, ovf_o}), 0);
        end

        // timeline: R2 R3 R4 R5 R6 R7 R8 through the pulse train
        c_end = (pe[NP-1] + P) / P + MX + 10;
        nx = 0;
        for (int c = 0; c <= c_end; c++) begin
            @(negedge clk);
            if (c > 0) begin
                cc = c - 1;
                while (nx < NP && kind[nx] == K_IGN) nx++;
                ev = (nx < NP) && kind[nx] == K_ACC && evc[nx] == cc;
                eo = (nx < NP) && kind[nx] == K_OVF && evc[nx] == cc;
                if (eo || ovf_o)                      tag = "R5";
                else if (cc >= ign_lo && cc <= ign_hi) tag = "R6";
                else if (cc * P >= bub_t)             tag = "R7";
                else                                  tag = "R4";
                chk(width_vld_o == ev, tag, "valid strobe", int'(width_vld_o), int'(ev));
                chk(ovf_o == eo, tag, "overflow strobe", int'(ovf_o), int'(eo));
                chk(!(width_vld_o && ovf_o), "R8", "strobes together", int'({width_vld_o, ovf_o}), 0);
                if (ev) begin
                    chk(int'(width_o) == ew[nx], tag, "width", int'(width_o), ew[nx]);
                    nx++;
                end else begin
                    if (eo) nx++;
                    chk(width_o == '0, tag, "width idle", int'(width_o), 0);
                end
            end
            tap_snap = snap_at(c);
        end
        chk(nx >= NP, "R4", "events consumed", nx, NP);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule